// File: doc/BRIEF.md
# Shift-Register Small FIFO

This block is a shallow first-in first-out queue for one clock domain. Its storage is a chain of registers rather than a circular buffer with read and write pointers. Every accepted write moves all stored words one stage deeper and places the new word in stage 0. The number of words in the chain is held by an up/down fill counter. The read port is a multiplexer whose select is the fill count minus one, so it always shows the oldest word held.

A read that happens without a write only lowers the count; the chain does not move. A read and a write in the same cycle move the chain and leave the count unchanged. A write while the queue is full is dropped, and so is a read while it is empty. Each dropped request raises a one-cycle error flag. The queue depth defaults to 16 and the word width is a parameter, typically 8 or 16 bits.

Top module: `srl_fifo`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the count to 0, empty to 1, and full, overflow and underflow to 0. The stored words are not cleared.
- R2: A write alone (push=1, pop=0) while not full raises the count by 1. If the queue was empty, dout shows the written word right after that edge.
- R3: dout shows the stored word at chain position count-1. This is the oldest word, so words leave in the order they were written. dout has no defined value while count is 0.
- R4: A read alone (pop=1, push=0) while not empty lowers the count by 1 without moving the chain. dout then shows the next-older word.
- R5: A read and a write together while not empty move the chain and keep the count. This applies when full too. dout then shows the word that was second oldest, or the new word if the count is 1.
- R6: full is 1 exactly when the count is 16 (DEPTH). empty is 1 exactly when the count is 0. The count never exceeds DEPTH.
- R7: A write alone while full leaves the count and dout unchanged. overflow is 1 for exactly the one cycle after that edge.
- R8: A read while empty lowers nothing. underflow is 1 for exactly the one cycle after that edge. If a write comes in the same cycle, the write is still accepted and the count becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Write request |
| din | input | WIDTH | Word to write |
| pop | input | 1 | Read request; removes the word shown on dout |
| dout | output | WIDTH | Oldest stored word |
| full | output | 1 | Count equals DEPTH |
| empty | output | 1 | Count equals zero |
| count | output | $clog2(DEPTH+1) | Number of stored words |
| overflow | output | 1 | One-cycle pulse after a dropped write |
| underflow | output | 1 | One-cycle pulse after a dropped read |

## Verification
The bench aims at the places where a shifting store and a count-selected tap can disagree:
- **Read and write together at count 1.** dout must switch to the new word. A design that moves the chain but also decrements the count would fall to empty and lose that word.
- **Read and write together when full.** A design that treats the write as overflow would stop the chain and show the same word twice.
- **Read and write together when empty.** This must still store the word. A design that cancels both requests would stay empty.
- **Error flags.** Each flag is sampled on the cycle after the dropped request and again one cycle later. A flag that sticks, or that is never raised, fails one of the two samples.
- **Full drain.** A complete fill and drain checks that the tap offset is right: an off-by-one tap gives the wrong word order.

// File: rtl/srl_fifo_pkg.sv
package srl_fifo_pkg;

  // Fill level after one cycle, given accepted write and read.
  function automatic int fill_next(input int fill, input bit wr_ok, input bit rd_ok);
    int r;
    r = fill;
    if (wr_ok && !rd_ok) r = fill + 1;
    if (rd_ok && !wr_ok) r = fill - 1;
    return r;
  endfunction

  // Chain position of the oldest word; position 0 when empty.
  function automatic int oldest_pos(input int fill);
    return (fill == 0) ? 0 : fill - 1;
  endfunction

endpackage

// File: rtl/srl_fifo_store.sv
module srl_fifo_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int TW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] wr_word,
  input  logic [TW-1:0]    tap_sel,
  output logic [WIDTH-1:0] rd_word
);

  logic [WIDTH-1:0] chain [DEPTH];

  // No reset on the data chain: only the fill counter defines validity.
  always_ff @(posedge clk) begin
    if (shift_en) begin
      chain[0] <= wr_word;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
    end
  end

  assign rd_word = chain[tap_sel];

endmodule

// File: rtl/srl_fifo_ctrl.sv
module srl_fifo_ctrl #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [CW-1:0] fill,
  output logic [TW-1:0] tap_sel,
  output logic          is_full,
  output logic          is_empty,
  output logic          ovf_q,
  output logic          udf_q
);
  import srl_fifo_pkg::*;

  logic          ovf_ev;
  logic          udf_ev;
  logic [CW-1:0] fill_d;

  assign is_full  = (fill == CW'(DEPTH));
  assign is_empty = (fill == '0);

  // A read frees a slot in the same cycle, so a full queue may take a write alongside it.
  assign rd_ok  = pop && !is_empty;
  assign wr_ok  = push && (!is_full || rd_ok);
  assign ovf_ev = push && !wr_ok;
  assign udf_ev = pop && is_empty;

  assign fill_d  = CW'(fill_next(int'(fill), wr_ok, rd_ok));
  assign tap_sel = TW'(oldest_pos(int'(fill)));

  always_ff @(posedge clk) begin
    if (rst) begin
      fill  <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      fill  <= fill_d;
      ovf_q <= ovf_ev;
      udf_q <= udf_ev;
    end
  end

endmodule

// File: rtl/srl_fifo.sv
module srl_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count,
  output logic             overflow,
  output logic             underflow
);

  logic          push_ok;
  logic          pop_ok;
  logic [TW-1:0] tap_sel;

  srl_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (pop),
    .wr_ok    (push_ok),
    .rd_ok    (pop_ok),
    .fill     (count),
    .tap_sel  (tap_sel),
    .is_full  (full),
    .is_empty (empty),
    .ovf_q    (overflow),
    .udf_q    (underflow)
  );

  srl_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .shift_en (push_ok),
    .wr_word  (din),
    .tap_sel  (tap_sel),
    .rd_word  (dout)
  );

endmodule

// File: rtl/srl_fifo_chk.sv
module srl_fifo_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             push,
  input logic             pop,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] dout,
  input logic             full,
  input logic             empty,
  input logic [CW-1:0]    count,
  input logic             overflow,
  input logic             underflow,
  input logic             push_ok,
  input logic             pop_ok
);

  AST_FILL_UP: assert property (@(posedge clk) disable iff (rst)
    (push_ok && !pop_ok) |=> (count == $past(count) + CW'(1))); // R2

  AST_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
    (push_ok && empty) |=> (dout == $past(din))); // R2

  AST_FILL_DOWN: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && !push_ok) |=> (count == $past(count) - CW'(1))); // R4

  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> $stable(count)); // R5

  AST_NOT_BOTH_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R6

  AST_DROP_WRITE: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |=> (overflow && $stable(count) && $stable(dout))); // R7

  AST_DROP_READ: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> underflow); // R8

  AST_READ_WRITE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (pop && push && empty) |=> (count == CW'(1))); // R8

endmodule

bind srl_fifo srl_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .push      (push),
  .pop       (pop),
  .din       (din),
  .dout      (dout),
  .full      (full),
  .empty     (empty),
  .count     (count),
  .overflow  (overflow),
  .underflow (underflow),
  .push_ok   (push_ok),
  .pop_ok    (pop_ok)
);

// File: tb/tb_srl_fifo.sv
`timescale 1ns/1ps
module tb_srl_fifo;
  localparam int W  = 8;
  localparam int D  = 16;
  localparam int CW = 5;
  localparam int NV = 14;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, push, pop;
  logic [W-1:0]  din;
  logic [W-1:0]  dout;
  logic          full, empty, overflow, underflow;
  logic [CW-1:0] count;

  srl_fifo #(.WIDTH(W), .DEPTH(D)) dut (
    .clk(clk), .rst(rst), .push(push), .din(din), .pop(pop),
    .dout(dout), .full(full), .empty(empty), .count(count),
    .overflow(overflow), .underflow(underflow)
  );

  int n_chk = 0;
  int n_bad = 0;

  // {push, pop, din[7:0], exp_count[4:0], exp_dout[7:0], check_dout, exp_ovf, exp_udf}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h00, 1'b0, 1'b0, 1'b1}, // R8 read on empty
    {1'b1, 1'b0, 8'hA1, 5'd1, 8'hA1, 1'b1, 1'b0, 1'b0}, // R2
    {1'b1, 1'b0, 8'hB2, 5'd2, 8'hA1, 1'b1, 1'b0, 1'b0}, // R3
    {1'b1, 1'b0, 8'hC3, 5'd3, 8'hA1, 1'b1, 1'b0, 1'b0}, // R3
    {1'b1, 1'b1, 8'hD4, 5'd3, 8'hB2, 1'b1, 1'b0, 1'b0}, // R5
    {1'b0, 1'b1, 8'h00, 5'd2, 8'hC3, 1'b1, 1'b0, 1'b0}, // R4
    {1'b0, 1'b1, 8'h00, 5'd1, 8'hD4, 1'b1, 1'b0, 1'b0}, // R4
    {1'b1, 1'b1, 8'hE5, 5'd1, 8'hE5, 1'b1, 1'b0, 1'b0}, // R5 count 1
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    {1'b1, 1'b1, 8'hF6, 5'd1, 8'hF6, 1'b1, 1'b0, 1'b1}, // R8 read+write on empty
    {1'b0, 1'b0, 8'h00, 5'd1, 8'hF6, 1'b1, 1'b0, 1'b0}, // R8 pulse ends
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h00, 1'b0, 1'b0, 1'b1}, // R8
    {1'b0, 1'b0, 8'h00, 5'd0, 8'h00, 1'b0, 1'b0, 1'b0}  // R8 pulse ends
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs over one rising edge, returns at the next falling edge.
  task automatic step(input logic p, input logic q, input logic [W-1:0] d);
    push = p; pop = q; din = d;
    @(posedge clk);
    @(negedge clk);
    push = 1'b0; pop = 1'b0; din = '0;
  endtask

  task automatic check_idle_after_reset(input string tag);
    check({tag, " R1 count"}, 32'(count), 32'd0);
    check({tag, " R1 empty"}, 32'(empty), 32'd1);
    check({tag, " R1 full"}, 32'(full), 32'd0);
    check({tag, " R1 overflow"}, 32'(overflow), 32'd0);
    check({tag, " R1 underflow"}, 32'(underflow), 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] model [$];
    rst = 1'b1; push = 1'b0; pop = 1'b0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_idle_after_reset("reset");

    // Table walk
    for (int v = 0; v < NV; v++) begin
      step(VEC[v][25], VEC[v][24], VEC[v][23:16]);
      check($sformatf("vec%0d R2/R4/R5 count", v), 32'(count), 32'(VEC[v][15:11]));
      check($sformatf("vec%0d R6 empty", v), 32'(empty), 32'(VEC[v][15:11] == 5'd0));
      check($sformatf("vec%0d R7 overflow", v), 32'(overflow), 32'(VEC[v][1]));
      check($sformatf("vec%0d R8 underflow", v), 32'(underflow), 32'(VEC[v][0]));
      if (VEC[v][2]) check($sformatf("vec%0d R3 dout", v), 32'(dout), 32'(VEC[v][10:3]));
    end

    // Fill to the top
    for (int i = 0; i < D; i++) begin
      step(1'b1, 1'b0, W'(8'h10 + i));
      model.push_back(W'(8'h10 + i));
      check("fill R2 count", 32'(count), 32'(i + 1));
      check("fill R6 full", 32'(full), 32'(i + 1 == D));
    end
    check("full R3 oldest", 32'(dout), 32'h10);

    // Write while full is dropped
    step(1'b1, 1'b0, 8'hEE);
    check("drop R7 count", 32'(count), 32'(D));
    check("drop R7 dout", 32'(dout), 32'h10);
    check("drop R7 overflow", 32'(overflow), 32'd1);
    step(1'b0, 1'b0, '0);
    check("drop R7 overflow pulse", 32'(overflow), 32'd0);

    // Read and write together while full
    step(1'b1, 1'b1, 8'h77);
    void'(model.pop_front());
    model.push_back(8'h77);
    check("full rw R5 count", 32'(count), 32'(D));
    check("full rw R5 dout", 32'(dout), 32'h11);
    check("full rw R7 no overflow", 32'(overflow), 32'd0);

    // Drain in order
    for (int i = 0; i < D; i++) begin
      check("drain R3 order", 32'(dout), 32'(model[0]));
      void'(model.pop_front());
      step(1'b0, 1'b1, '0);
      check("drain R4 count", 32'(count), 32'(D - 1 - i));
    end
    check("drained R6 empty", 32'(empty), 32'd1);
    check("drained R6 full", 32'(full), 32'd0);

    // Reset while holding data
    step(1'b1, 1'b0, 8'h31);
    step(1'b1, 1'b0, 8'h32);
    step(1'b1, 1'b0, 8'h33);
    rst = 1'b1;
    step(1'b1, 1'b0, 8'h34);
    rst = 1'b0;
    check_idle_after_reset("mid reset");
    step(1'b1, 1'b0, 8'h5A);
    check("post reset R2 dout", 32'(dout), 32'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule